// File: doc/BRIEF.md
# PLL Lock Timer and Configuration Sequencer

This block is the digital control shell that sits beside an external phase-locked loop. Software writes the pre-divider, feedback multiplier and post-scaler exponent into one register. The output frequency is then multiplier × reference / (pre-divider × 2^exponent). A second register carries an enable bit and a bypass bit, and a third holds a lock wait, counted in reference-clock cycles. The divider values and both control bits drive the oscillator and the downstream clock mux directly.

The expected software order is: program the dividers, set bypass as needed, enable, poll the lock flag, and only then move the consumer clock mux onto the multiplied clock. After enable, the block counts down the programmed wait and then raises a locked flag. A wait of 270 × pre-divider cycles covers the worst case. Changing the dividers while enabled drops lock and starts a fresh wait. Disabling drops lock at once. The locked flag is also readable through a status register.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset, every register reads zero, and the enable, bypass and locked outputs are low.
- R2: The divider register at address 0 holds the multiplier in bits [9:0], the pre-divider in bits [21:16] and the exponent in bits [26:24]. It reads back with all other bits zero, and its fields appear on the divider outputs one cycle after the write.
- R3: The control register at address 1 holds enable in bit 0 and bypass in bit 1. Both outputs follow one cycle after the write, and bypass has no effect on lock timing.
- R4: The lock-wait register at address 2 holds a 16-bit count in bits [15:0].
- R5: A write that sets enable while it was clear starts the wait with count N. Locked rises on the (N+1)-th clock edge after the write edge, so N = 0 gives lock one cycle after enable.
- R6: A write that clears enable forces locked low at that write edge, and locked stays low with no further counting.
- R7: A divider write while enabled clears locked at the write edge and restarts the full wait from the current lock-wait value.
- R8: A control write that keeps enable set while already enabled neither restarts the wait nor clears locked.
- R9: Address 3 is a read-only status word with locked in bit 0 and zeros elsewhere. Writes to it change no register.
- R10: Writing the lock-wait register during a wait does not alter that wait; the new value applies to the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Combinational read data |
| pll_p | output | 6 | Pre-divider to the oscillator |
| pll_m | output | 10 | Feedback multiplier to the oscillator |
| pll_s | output | 3 | Post-scaler exponent to the oscillator |
| pll_en | output | 1 | Oscillator enable |
| pll_bypass | output | 1 | Selects the reference clock straight through downstream |
| pll_locked | output | 1 | Lock wait has elapsed since the last start |

## Verification
A timer that loads the wrong count, or decrements at the wrong rate, shows up as locked rising early or late. The bench catches this on the first enable, exact to the cycle, because it counts edges from the enabling write until the flag is seen. A missed restart or a missed stop leaves locked high straight after a divider write or a disable. That is visible one cycle later at both the flag pin and the status read. A corrupted field or register shows up on the immediate readback and on the divider outputs.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    A_DIV  = 2'd0,
    A_CTRL = 2'd1,
    A_LOCK = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    T_IDLE   = 2'd0,
    T_COUNT  = 2'd1,
    T_LOCKED = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int P_W    = 6,
  parameter int M_W    = 10,
  parameter int S_W    = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              locked,
  output logic [DATA_W-1:0] rd_data,
  output logic [P_W-1:0]    p_q,
  output logic [M_W-1:0]    m_q,
  output logic [S_W-1:0]    s_q,
  output logic              en_q,
  output logic              byp_q,
  output logic [CNT_W-1:0]  lock_cnt_q,
  output logic              start,
  output logic              stop
);
  localparam int M_LSB   = 0;
  localparam int P_LSB   = 16;
  localparam int S_LSB   = 24;
  localparam int EN_BIT  = 0;
  localparam int BYP_BIT = 1;

  logic [P_W-1:0]   p_d;
  logic [M_W-1:0]   m_d;
  logic [S_W-1:0]   s_d;
  logic             en_d, byp_d;
  logic [CNT_W-1:0] lock_cnt_d;
  logic             div_wr, ctrl_wr, lock_wr;

  always_comb begin
    div_wr  = wr_en && (wr_addr == A_DIV);
    ctrl_wr = wr_en && (wr_addr == A_CTRL);
    lock_wr = wr_en && (wr_addr == A_LOCK);
    p_d = p_q; m_d = m_q; s_d = s_q;
    en_d = en_q; byp_d = byp_q; lock_cnt_d = lock_cnt_q;
    if (div_wr) begin
      m_d = wr_data[M_LSB +: M_W];
      p_d = wr_data[P_LSB +: P_W];
      s_d = wr_data[S_LSB +: S_W];
    end
    if (ctrl_wr) begin
      en_d  = wr_data[EN_BIT];
      byp_d = wr_data[BYP_BIT];
    end
    if (lock_wr) lock_cnt_d = wr_data[CNT_W-1:0];
    start = (ctrl_wr && wr_data[EN_BIT] && !en_q) || (div_wr && en_q);
    stop  = ctrl_wr && !wr_data[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0; m_q <= '0; s_q <= '0;
      en_q <= 1'b0; byp_q <= 1'b0; lock_cnt_q <= '0;
    end else begin
      p_q <= p_d; m_q <= m_d; s_q <= s_d;
      en_q <= en_d; byp_q <= byp_d; lock_cnt_q <= lock_cnt_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_DIV: begin
        rd_data[M_LSB +: M_W] = m_q;
        rd_data[P_LSB +: P_W] = p_q;
        rd_data[S_LSB +: S_W] = s_q;
      end
      A_CTRL: begin
        rd_data[EN_BIT]  = en_q;
        rd_data[BYP_BIT] = byp_q;
      end
      A_LOCK:  rd_data[CNT_W-1:0] = lock_cnt_q;
      default: rd_data[0] = locked;
    endcase
  end

  // R9: a write to the status address leaves every register unchanged
  assert_stat_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STAT) |=> $stable({p_q, m_q, s_q, en_q, byp_q, lock_cnt_q}));

  // R3: the enable and bypass registers take the written bits on the next edge
  assert_ctrl_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (en_q == $past(wr_data[EN_BIT]) && byp_q == $past(wr_data[BYP_BIT])));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
  import pll_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] load_val,
  output logic             locked
);
  tmr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (stop) begin
      state_d = T_IDLE;
      cnt_d   = '0;
    end else if (start) begin
      state_d = T_COUNT;
      cnt_d   = load_val;
    end else if (state_q == T_COUNT) begin
      if (cnt_q == '0) state_d = T_LOCKED;
      else             cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= T_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign locked = (state_q == T_LOCKED);

  // R6: a stop leaves the timer idle and unlocked
  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state_q == T_IDLE && !locked));

  // R7: a start drops lock and loads the programmed wait
  assert_start_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (!locked && state_q == T_COUNT && cnt_q == $past(load_val)));

  // R5: the wait decreases by one per cycle while undisturbed
  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == T_COUNT && cnt_q != '0 && !start && !stop)
      |=> (state_q == T_COUNT && cnt_q == $past(cnt_q) - 1'b1));

  // R5: an exhausted wait locks on the next edge
  assert_lock_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == T_COUNT && cnt_q == '0 && !start && !stop) |=> locked);
endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
  import pll_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int P_W    = 6,
  parameter int M_W    = 10,
  parameter int S_W    = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [P_W-1:0]    pll_p,
  output logic [M_W-1:0]    pll_m,
  output logic [S_W-1:0]    pll_s,
  output logic              pll_en,
  output logic              pll_bypass,
  output logic              pll_locked
);
  logic             rst_int_n;
  logic             start, stop;
  logic [CNT_W-1:0] lock_cnt;

  pll_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  pll_cfg_regs #(
    .DATA_W(DATA_W), .P_W(P_W), .M_W(M_W), .S_W(S_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .locked(pll_locked),
    .rd_data(rd_data), .p_q(pll_p), .m_q(pll_m), .s_q(pll_s),
    .en_q(pll_en), .byp_q(pll_bypass), .lock_cnt_q(lock_cnt),
    .start(start), .stop(stop)
  );

  pll_lock_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .start(start), .stop(stop),
    .load_val(lock_cnt), .locked(pll_locked)
  );

  // R6: lock is never reported while the oscillator is disabled
  assert_locked_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    pll_locked |-> pll_en);
endmodule

// File: tb/tb_pll_lock_seq.sv
module tb_pll_lock_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic [5:0]  pll_p;
  logic [9:0]  pll_m;
  logic [2:0]  pll_s;
  logic        pll_en, pll_bypass, pll_locked;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pll_lock_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pll_p(pll_p), .pll_m(pll_m), .pll_s(pll_s), .pll_en(pll_en),
    .pll_bypass(pll_bypass), .pll_locked(pll_locked)
  );

  typedef struct packed {
    logic [5:0]  p;
    logic [9:0]  m;
    logic [2:0]  s;
    logic [15:0] n;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{p: 6'd3,  m: 10'd200,  s: 3'd1, n: 16'd810},
    '{p: 6'd1,  m: 10'd100,  s: 3'd0, n: 16'd270},
    '{p: 6'd4,  m: 10'd250,  s: 3'd2, n: 16'd0},
    '{p: 6'd2,  m: 10'd64,   s: 3'd3, n: 16'd1},
    '{p: 6'd6,  m: 10'd500,  s: 3'd1, n: 16'd5},
    '{p: 6'd63, m: 10'd1023, s: 3'd7, n: 16'd17010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_lock(output int cyc);
    cyc = 0;
    while (!pll_locked && cyc < 70000) begin
      @(negedge clk); cyc++;
    end
  endtask

  function automatic logic [31:0] div_word(input logic [5:0] p, input logic [9:0] m, input logic [2:0] s);
    div_word = {5'd0, s, 2'd0, p, 6'd0, m};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cyc;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); chk("R1 reg reset", d, 32'd0);
    end
    chk("R1 outputs reset", {29'd0, pll_en, pll_bypass, pll_locked}, 32'd0);

    // Table walk: R2, R4, R5, R9, R6
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VEC[i];
      wr(2'd0, div_word(v.p, v.m, v.s) | 32'hE0C0_FC00);
      rd(2'd0, d); chk("R2 divider readback", d, div_word(v.p, v.m, v.s));
      chk("R2 divider outputs", {13'd0, pll_s, pll_p, pll_m}, {13'd0, v.s, v.p, v.m});
      wr(2'd2, {16'hABCD, v.n});
      rd(2'd2, d); chk("R4 lock count readback", d, {16'd0, v.n});
      $display("vector %0d: fout = %0d kHz from 24000 kHz reference", i,
               (24000 * int'(v.m)) / (int'(v.p) << v.s));
      wr(2'd1, 32'h1);
      chk("R3 enable output", {31'd0, pll_en}, 32'd1);
      wait_lock(cyc);
      chk("R5 lock latency", cyc, int'(v.n) + 1);
      rd(2'd3, d); chk("R9 status locked", d, 32'd1);
      wr(2'd1, 32'h0);
      chk("R6 disable clears lock", {31'd0, pll_locked}, 32'd0);
      rd(2'd3, d); chk("R9 status cleared", d, 32'd0);
    end

    // R6: disable mid-wait, no lock afterwards
    wr(2'd2, 32'd20);
    wr(2'd1, 32'h1);
    repeat (3) @(negedge clk);
    wr(2'd1, 32'h0);
    repeat (40) @(negedge clk);
    chk("R6 stays unlocked after disable", {31'd0, pll_locked}, 32'd0);

    // R7: divider write while enabled restarts the full wait
    wr(2'd2, 32'd10);
    wr(2'd1, 32'h1);
    repeat (4) @(negedge clk);
    wr(2'd0, div_word(6'd5, 10'd300, 3'd2));
    chk("R7 lock cleared by divider write", {31'd0, pll_locked}, 32'd0);
    wait_lock(cyc);
    chk("R7 restart latency", cyc, 11);
    wr(2'd0, div_word(6'd2, 10'd120, 3'd1));
    chk("R7 lock dropped after lock", {31'd0, pll_locked}, 32'd0);
    wait_lock(cyc);
    chk("R7 second restart latency", cyc, 11);

    // R8 and R3: rewrite enable with bypass set, lock stays
    wr(2'd1, 32'h3);
    chk("R8 lock kept", {31'd0, pll_locked}, 32'd1);
    chk("R3 bypass output", {31'd0, pll_bypass}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R8 lock still kept", {31'd0, pll_locked}, 32'd1);
    rd(2'd1, d); chk("R3 control readback", d, 32'h3);

    // R9: status writes ignored
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R9 divider untouched", d, div_word(6'd2, 10'd120, 3'd1));
    rd(2'd2, d); chk("R9 lock count untouched", d, 32'd10);
    rd(2'd3, d); chk("R9 status only bit0", d, 32'd1);

    // R10 and R3: lock count written mid-wait does not change it; bypass on
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd30);
    wr(2'd1, 32'h3);
    repeat (2) @(negedge clk);
    wr(2'd2, 32'd2);
    wait_lock(cyc);
    chk("R10 wait unchanged by lock write", cyc, 28);
    wr(2'd1, 32'h0);
    wr(2'd1, 32'h1);
    chk("R3 bypass cleared", {31'd0, pll_bypass}, 32'd0);
    wait_lock(cyc);
    chk("R10 new count applies next start", cyc, 3);

    // R5: zero count locks one cycle after enable
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'h1);
    chk("R5 zero count lock", {31'd0, pll_locked}, 32'd0);
    @(negedge clk);
    chk("R5 zero count lock one cycle", {31'd0, pll_locked}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule